// File: doc/BRIEF.md
# MDIO Management Master

This block runs management frames on the two-wire PHY management bus. A host pulses a start request together with a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then produces the whole frame on the line. The management clock is divided down from the system clock. The block drives the data output and its output enable, and for a read it samples the data input. When the frame completes it returns a 16-bit read value and an error flag.

Every frame bit, the preamble included, occupies one slot of three equal phases. In the setup phase the clock is low and the data is presented. In the high phase the clock is high. In the hold phase the clock is low again. Each phase lasts `PHASE_CYCLES` system clocks. The default of 14 keeps the management clock at or below 2.5 MHz from a 100 MHz system clock. A frame is always 64 slots followed by one trailing low phase.

For a read, the line is handed to the PHY and back again only while the clock is low. The turnaround response of the PHY is treated as an error indicator. `PHASE_CYCLES` must be at least 3, so that the two-flop input synchroniser settles before each sample is taken.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 rising edges of `mdc` during which `md_out` is 1 and `md_oe` is 1.
- R2: `md_out` and `md_oe` change only while `mdc` is low. They never change while `mdc` is high or in the cycle in which `mdc` rises.
- R3: After the preamble, the bits seen at successive rising edges are a start code 01, then an opcode (10 for read, 01 for write), then the PHY address and then the register address, each field most significant bit first.
- R4: A write frame continues with the pattern 10 and then the 16 data bits MSB first, for 64 rising edges in total. `md_oe` stays 1 for the whole frame and afterwards.
- R5: A read frame takes `md_oe` to 0 after the register address while `mdc` is low, with no `mdc` edge at that moment. `md_oe` stays 0 for the last 18 rising edges of the frame (turnaround, idle, 16 data bits).
- R6: If `md_in` is 1 just before the 48th rising edge (the sample after the turnaround clock), the read ends with `rsp_err`=1 and `rsp_rdata`=0. Otherwise `rsp_err`=0.
- R7: A read captures `md_in` just before rising edges 49 to 64, MSB first, into `rsp_rdata`.
- R8: After the last read bit, `md_oe` returns to 1 while `mdc` is low, with no `mdc` edge at that moment.
- R9: Within a frame, `mdc` is high for exactly `PHASE_CYCLES` system clocks. It is low for exactly 2·`PHASE_CYCLES` between consecutive pulses, so each bit lasts 3·`PHASE_CYCLES` system clocks.
- R10: A `cmd_start` pulse while `busy` is 1 is ignored. The running frame continues unchanged and only one `done` pulse occurs.
- R11: `done` is a one-cycle pulse that appears 193·`PHASE_CYCLES` clocks after the clock edge that accepts the start. `busy` falls in that same cycle. `rsp_rdata` and `rsp_err` then stay unchanged until the next accepted start.
- R12: After reset and whenever idle, `mdc`=0, `md_oe`=1 and `md_out`=1. After reset, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle request to run a frame; accepted only when idle |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Value sent by a write |
| rsp_rdata | output | 16 | Value returned by the last read (0 on error) |
| rsp_err | output | 1 | Last read saw no PHY response |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at frame completion |
| mdc | output | 1 | Management clock |
| md_out | output | 1 | Data value driven toward the PHY |
| md_oe | output | 1 | Output enable for the data pin driver |
| md_in | input | 1 | Data pin level as seen from the pin |

## Verification
The clock edge that accepts a start sets `busy` from the next cycle. The first `mdc` rise comes `PHASE_CYCLES`+1 edges later, because the line outputs pass through one register stage. `done` and the read results are valid 193·`PHASE_CYCLES` edges after acceptance. The bench counts edges from the accepting edge and requires `done` at exactly that count, with `busy` low and the line idle in that cycle. All line observations are taken on the falling system clock. Line bits are recorded at each observed `mdc` rise. The PHY model changes `md_in` only after an observed `mdc` fall, which leaves at least `PHASE_CYCLES` clocks before the next sample.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int SLOT_W     = 6;
  localparam int PRE_SLOTS  = 32;
  localparam int START_SLOT = PRE_SLOTS;
  localparam int OP_SLOT    = START_SLOT + 2;
  localparam int PHY_SLOT   = OP_SLOT + 2;
  localparam int REG_SLOT   = PHY_SLOT + ADDR_W;
  localparam int TA_SLOT    = REG_SLOT + ADDR_W;
  localparam int ERR_SLOT   = TA_SLOT + 1;
  localparam int DATA_SLOT  = TA_SLOT + 2;
  localparam int LAST_SLOT  = DATA_SLOT + DATA_W - 1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SLOT = 2'd1,
    SEQ_TAIL = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_HIGH  = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  // Level the master presents in a given slot (used only when it drives).
  function automatic logic slot_bit(mdio_cmd_t c, logic [SLOT_W-1:0] slot);
    int                s;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    s = int'(slot);
    if (s < START_SLOT) return 1'b1;
    if (s < OP_SLOT)    return (s == START_SLOT + 1);
    if (s < PHY_SLOT)   return c.rd ? (s == OP_SLOT) : (s == OP_SLOT + 1);
    if (s < REG_SLOT) begin
      a = c.phy >> (REG_SLOT - 1 - s);
      return a[0];
    end
    if (s < TA_SLOT) begin
      a = c.regad >> (TA_SLOT - 1 - s);
      return a[0];
    end
    if (c.rd) return 1'b1;
    if (s < DATA_SLOT) return (s == TA_SLOT);
    d = c.wdata >> (LAST_SLOT - s);
    return d[0];
  endfunction

  // Whether the master owns the data line in a given slot.
  function automatic logic slot_drives(logic rd, logic [SLOT_W-1:0] slot);
    return !(rd && (int'(slot) >= TA_SLOT));
  endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int PHASE_CYCLES = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              tick,
  output seq_state_e        state,
  output phase_e            phase,
  output logic [SLOT_W-1:0] slot,
  output logic              busy,
  output logic              done,
  output logic              setup_end
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      phase <= PH_SETUP;
      slot  <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == SEQ_TAIL) && tick;
      case (state)
        SEQ_IDLE: if (go) begin
          state <= SEQ_SLOT;
          phase <= PH_SETUP;
          slot  <= '0;
        end
        SEQ_SLOT: if (tick) begin
          case (phase)
            PH_SETUP: phase <= PH_HIGH;
            PH_HIGH:  phase <= PH_HOLD;
            default: begin
              phase <= PH_SETUP;
              if (slot == LAST) state <= SEQ_TAIL;
              else              slot  <= slot + 1'b1;
            end
          endcase
        end
        SEQ_TAIL: if (tick) state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SEQ_IDLE);
  assign setup_end = (state == SEQ_SLOT) && (phase == PH_SETUP) && tick;
endmodule

// File: rtl/mdio_line_drv.sv
module mdio_line_drv
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  phase_e            phase,
  input  logic [SLOT_W-1:0] slot,
  input  mdio_cmd_t         cmd,
  output logic              mdc,
  output logic              md_out,
  output logic              md_oe
);
  logic mdc_n, out_n, oe_n;

  always_comb begin
    mdc_n = 1'b0;
    out_n = 1'b1;
    oe_n  = 1'b1;
    if (state == SEQ_SLOT) begin
      mdc_n = (phase == PH_HIGH);
      oe_n  = slot_drives(cmd.rd, slot);
      out_n = oe_n ? slot_bit(cmd, slot) : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc    <= 1'b0;
      md_out <= 1'b1;
      md_oe  <= 1'b1;
    end else begin
      mdc    <= mdc_n;
      md_out <= out_n;
      md_oe  <= oe_n;
    end
  end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [SLOT_W-1:0] slot,
  input  logic              md_in,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic sync_a, sync_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= md_in;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err   <= 1'b0;
      rdata <= '0;
    end else if (clear) begin
      err   <= 1'b0;
      rdata <= '0;
    end else if (sample) begin
      if (int'(slot) == ERR_SLOT)
        err <= sync_b;
      else if (int'(slot) >= DATA_SLOT)
        rdata <= {rdata[DATA_W-2:0], sync_b & ~err};
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PHASE_CYCLES = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_read,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        md_out,
  output logic        md_oe,
  input  logic        md_in
);
  seq_state_e        state;
  phase_e            phase;
  logic [SLOT_W-1:0] slot;
  logic              tick;
  logic              go;
  logic              setup_end;
  logic              sample_evt;
  mdio_cmd_t         cmd_q;

  assign go = cmd_start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmd_q <= '0;
    else if (go) cmd_q <= '{rd: cmd_read, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};
  end

  mdio_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .tick     (tick),
    .state    (state),
    .phase    (phase),
    .slot     (slot),
    .busy     (busy),
    .done     (done),
    .setup_end(setup_end)
  );

  mdio_line_drv u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .phase (phase),
    .slot  (slot),
    .cmd   (cmd_q),
    .mdc   (mdc),
    .md_out(md_out),
    .md_oe (md_oe)
  );

  // Named event: a read sample is being taken from the line this cycle.
  assign sample_evt = setup_end && cmd_q.rd && (int'(slot) >= ERR_SLOT);

  mdio_rx_capture u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (go),
    .sample(sample_evt),
    .slot  (slot),
    .md_in (md_in),
    .rdata (rsp_rdata),
    .err   (rsp_err)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int PHASE_CYCLES = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        md_out,
  input logic        md_oe,
  input logic        rsp_err,
  input logic [15:0] rsp_rdata,
  input logic        sample_evt
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (mdc) hi_cnt <= hi_cnt + 1'b1;
    else          hi_cnt <= '0;
  end

  // R2
  line_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(md_out) && $stable(md_oe)));

  // R2
  line_steady_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(md_out) && $stable(md_oe)));

  // R5
  release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(md_oe) |-> (!mdc && !$past(mdc)));

  // R5
  sample_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (!md_oe && !mdc));

  // R8
  reclaim_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(md_oe) |-> (!mdc && !$past(mdc)));

  // R9
  mdc_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == 16'(PHASE_CYCLES)));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_start) |=> ($stable(rsp_rdata) && $stable(rsp_err)));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_err) |-> (rsp_rdata == 16'h0000));

  // R12
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && md_oe && md_out));
endmodule

bind mdio_master mdio_master_chk #(.PHASE_CYCLES(PHASE_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .busy      (busy),
  .done      (done),
  .mdc       (mdc),
  .md_out    (md_out),
  .md_oe     (md_oe),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .sample_evt(sample_evt)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int PH       = 14;
  localparam int FRAME_CY = 193 * PH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic        cmd_read = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        busy, done, mdc, md_out, md_oe;
  logic        md_in = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  // PHY model controls
  logic        phy_err  = 1'b0;
  logic [63:0] phy_data = '0;

  // monitor state
  int          rise_cnt = 0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe   = '0;
  int          hi_run = 0, lo_run = 0;
  int          hi_min = 0, hi_max = 0, lo_min = 0;
  int          edge_viol = 0;
  logic        mdc_prev = 1'b0, busy_prev = 1'b0, out_prev = 1'b1, oe_prev = 1'b1;

  mdio_master #(.PHASE_CYCLES(PH)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .busy(busy), .done(done),
    .mdc(mdc), .md_out(md_out), .md_oe(md_oe), .md_in(md_in)
  );

  always #5 clk = ~clk;

  // Line monitor and PHY model, all on the falling system clock.
  always @(negedge clk) begin
    logic [63:0] sh;
    if (busy && !busy_prev) begin
      rise_cnt = 0; cap_bits = '0; cap_oe = '0;
      hi_run = 0; lo_run = 0; hi_min = 1000000; hi_max = 0; lo_min = 1000000;
      edge_viol = 0; md_in = 1'b1;
    end
    if (mdc && ((md_out !== out_prev) || (md_oe !== oe_prev))) edge_viol++;
    if (mdc && !mdc_prev) begin
      rise_cnt++;
      cap_bits = {cap_bits[62:0], md_out};
      cap_oe   = {cap_oe[62:0], md_oe};
      if (rise_cnt > 1 && lo_run < lo_min) lo_min = lo_run;
      hi_run = 1;
    end else if (mdc) begin
      hi_run++;
    end
    if (!mdc && mdc_prev) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      lo_run = 1;
      if (rise_cnt == 47) md_in = phy_err;
      else if (rise_cnt >= 48 && rise_cnt <= 63) begin
        sh = phy_data >> (63 - rise_cnt);
        md_in = sh[0];
      end else md_in = 1'b1;
    end else if (!mdc) begin
      lo_run++;
    end
    mdc_prev = mdc; busy_prev = busy; out_prev = md_out; oe_prev = md_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input int poke,
                           output int first_done, output int ndone, output int dwidth);
    int n;
    @(negedge clk);
    cmd_read = rd; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd; cmd_start = 1'b1;
    n = 0; first_done = 0; ndone = 0; dwidth = 0;
    while (n < FRAME_CY + 200 && (first_done == 0 || n < first_done + 20)) begin
      @(posedge clk); n++;
      @(negedge clk);
      cmd_start = (n == poke);
      if (n == poke) begin
        cmd_read = ~rd; cmd_phy = ~pa; cmd_reg = ~ra; cmd_wdata = ~wd;
      end
      if (done) begin
        dwidth++;
        if (!(n > 1 && dwidth > 1)) ndone++;
        if (first_done == 0) first_done = n;
      end else if (dwidth > 0 && first_done != n) begin
        dwidth = dwidth; // pulse ended
      end
    end
  endtask

  task automatic check_timing_and_idle(input string tag);
    chk({"R9 high width min ", tag}, 64'(hi_min), 64'(PH));
    chk({"R9 high width max ", tag}, 64'(hi_max), 64'(PH));
    chk({"R9 low width ", tag}, 64'(lo_min), 64'(2 * PH));
    chk({"R2 no change while mdc high ", tag}, 64'(edge_viol), 64'd0);
    chk({"R12 idle line ", tag}, {61'd0, mdc, md_oe, md_out}, 64'b011);
    chk({"R11 busy low after done ", tag}, 64'(busy), 64'd0);
  endtask

  task automatic test_reset;
    chk("R12 reset busy", 64'(busy), 64'd0);
    chk("R12 reset done", 64'(done), 64'd0);
    chk("R12 reset line", {61'd0, mdc, md_oe, md_out}, 64'b011);
  endtask

  task automatic test_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    int fd, nd, dw;
    logic [63:0] exp;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd};
    run_frame(1'b0, pa, ra, wd, 0, fd, nd, dw);
    chk("R11 done latency", 64'(fd), 64'(FRAME_CY + 1));
    chk("R11 done width", 64'(dw), 64'd1);
    chk("R4 rising edges", 64'(rise_cnt), 64'd64);
    chk("R1 preamble", cap_bits[63:32], 64'hFFFF_FFFF);
    chk("R3 header", 64'(cap_bits[63:18]), 64'(exp[63:18]));
    chk("R4 write frame", cap_bits, exp);
    chk("R4 enable held", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    check_timing_and_idle("write");
  endtask

  task automatic test_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] pd);
    int fd, nd, dw;
    logic [45:0] hdr;
    logic [15:0] held;
    hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
    phy_err = 1'b0; phy_data = {48'd0, pd};
    run_frame(1'b1, pa, ra, 16'h0, 0, fd, nd, dw);
    chk("R11 done latency read", 64'(fd), 64'(FRAME_CY + 1));
    chk("R1 preamble read", cap_bits[63:32], 64'hFFFF_FFFF);
    chk("R3 read header", 64'(cap_bits[63:18]), 64'(hdr));
    chk("R5 enable pattern", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
    chk("R7 read data", 64'(rsp_rdata), 64'(pd));
    chk("R6 no error", 64'(rsp_err), 64'd0);
    chk("R8 enable back", 64'(md_oe), 64'd1);
    check_timing_and_idle("read");
    held = rsp_rdata;
    repeat (50) @(negedge clk);
    chk("R11 result held", {47'd0, rsp_err, rsp_rdata}, {47'd0, 1'b0, held});
  endtask

  task automatic test_read_err;
    int fd, nd, dw;
    phy_err = 1'b1; phy_data = 64'hA5A5;
    run_frame(1'b1, 5'h0C, 5'h03, 16'h0, 0, fd, nd, dw);
    chk("R6 error flag", 64'(rsp_err), 64'd1);
    chk("R6 data zeroed", 64'(rsp_rdata), 64'd0);
    chk("R8 enable back after error", 64'(md_oe), 64'd1);
    phy_err = 1'b0;
  endtask

  task automatic test_busy_ignore;
    int fd, nd, dw;
    logic [63:0] exp;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'h3C96};
    run_frame(1'b0, 5'h15, 5'h0A, 16'h3C96, 1000, fd, nd, dw);
    chk("R10 frame unchanged", cap_bits, exp);
    chk("R10 single done", 64'(dw), 64'd1);
    chk("R10 done latency", 64'(fd), 64'(FRAME_CY + 1));
    chk("R10 idle after", 64'(busy), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_write(5'h01, 5'h1F, 16'h8001);
    test_write(5'h1E, 5'h00, 16'h7FFE);
    test_read(5'h11, 5'h12, 16'hC3A5);
    test_read(5'h00, 5'h1F, 16'h0001);
    test_read_err();
    test_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule